// File: doc/BRIEF.md
# Pin-Multiplexed GPIO Port Controller

This block is one 32-pin port of a general-purpose I/O bank. Software configures it through a word-addressed register bus. Every configuration register is changed only by writing a mask of ones to a set, clear or toggle alias. Plain writes to a register's base address do nothing. This lets several software agents change different pins without read-modify-write races.

For each pin, an ownership bit picks who drives the pad. When the bit is 1, the port drives the pad from its own output-value and output-enable bits. When it is 0, one of up to eight peripheral functions drives the pad, selected by a 3-bit code spread across three function-select registers. Peripheral output and output-enable signals arrive as flat per-function vectors. The port also produces pull-up and pull-down controls; enabling both holds a pin in bus-keeper mode.

The pad input is synchronised through two flops before it can be read back. This readback is separate from the output-value register. A second read-only word gives the level that a pin emulating an open-drain output would show. That emulation holds the output value at 0 and toggles the output enable.

Top module: `pinmux_port`

## Requirements
- R1: An access is accepted only when `bus_valid` is 1, `bus_addr[11:8]` equals parameter `PORT_ID` (default 2) and `bus_addr[1:0]` is 0. A write to any other port index changes no register, and a read of it returns 0.
- R2: `bus_addr[7:4]` selects the register word: 0 pin ownership, 1 output enable, 2 output value, 3 pull-up, 4 pull-down, 5/6/7 function-select bit 0/1/2, 8 synchronised pad level (read-only), 9 open-drain level (read-only). `bus_addr[3:2]` selects the access kind: 0 base, 1 set, 2 clear, 3 toggle.
- R3: A write to the set alias ORs the write data into the register; bits written as 0 keep their value.
- R4: A write to the clear alias clears every register bit whose write-data bit is 1.
- R5: A write to the toggle alias inverts every register bit whose write-data bit is 1.
- R6: Writes to a base address, and writes of any kind to the read-only words 8 and 9, change no state.
- R7: A base-address read returns the register. A read of a set, clear or toggle alias returns 0, and so does a read of a word numbered 10 or above.
- R8: After reset every pin is owned by the port, output enable, output value, both pulls and all function-select bits are 0, and both pad outputs are 0.
- R9: For a pin whose ownership bit is 1, `pad_out_o` equals its output-value bit and `pad_oe_o` equals its output-enable bit.
- R10: For a pin whose ownership bit is 0, the code c = {fsel2, fsel1, fsel0} for that pin selects `fn_out_i[c*32+pin]` onto `pad_out_o` and `fn_oe_i[c*32+pin]` onto `pad_oe_o`.
- R11: A change on `pad_in_i` is seen in a read of word 8 after the second rising clock edge, and not after the first.
- R12: A read of word 9 returns the bitwise inverse of the output-enable register.
- R13: `pull_up_o` and `pull_dn_o` follow the pull registers; a pin with both set (bus keeper) has both outputs at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request for this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address: port index, word, access kind |
| bus_wdata | input | 32 | Write mask or data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in_i | input | 32 | Pad levels, asynchronous |
| pad_out_o | output | 32 | Value driven to each pad |
| pad_oe_o | output | 32 | Drive enable for each pad |
| pull_up_o | output | 32 | Pull-up enable per pin |
| pull_dn_o | output | 32 | Pull-down enable per pin |
| fn_out_i | input | NUM_FN*32 | Peripheral output values, function-major |
| fn_oe_i | input | NUM_FN*32 | Peripheral output enables, function-major |

## Verification
The assertions assume that the bus signals are settled and free of X at each rising edge while reset is released. They also assume that `bus_valid` marks at most one access per cycle, so a write and its stability check never overlap a second write to the same word. The stimulus changes bus and pad inputs only on falling edges and returns `bus_valid` to 0 before the next rising edge after every read. Peripheral vectors are held constant while pad outputs are sampled, so each pin's expected level depends only on the programmed function code.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
    localparam int PINS    = 32;
    localparam int ADDR_W  = 12;
    localparam int PORT_W  = 4;
    localparam int SLOT_W  = 4;
    localparam int FSEL_W  = 3;
    localparam int MAX_FN  = 1 << FSEL_W;

    typedef enum logic [1:0] {
        ACC_BASE = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2,
        ACC_TGL  = 2'd3
    } acc_e;

    typedef enum logic [SLOT_W-1:0] {
        SL_OWN  = 4'd0,
        SL_OE   = 4'd1,
        SL_OV   = 4'd2,
        SL_PU   = 4'd3,
        SL_PD   = 4'd4,
        SL_FS0  = 4'd5,
        SL_FS1  = 4'd6,
        SL_FS2  = 4'd7,
        SL_LVL  = 4'd8,
        SL_ODL  = 4'd9
    } slot_e;

    typedef struct packed {
        logic [PINS-1:0]              own;
        logic [PINS-1:0]              oe;
        logic [PINS-1:0]              ov;
        logic [PINS-1:0]              pu;
        logic [PINS-1:0]              pd;
        logic [FSEL_W-1:0][PINS-1:0]  fs;
    } cfg_t;

    function automatic logic [PINS-1:0] apply_alias(
        input acc_e            kind,
        input logic [PINS-1:0] cur,
        input logic [PINS-1:0] mask
    );
        case (kind)
            ACC_SET: apply_alias = cur | mask;
            ACC_CLR: apply_alias = cur & ~mask;
            ACC_TGL: apply_alias = cur ^ mask;
            default: apply_alias = cur;
        endcase
    endfunction
endpackage

// File: rtl/pinmux_regfile.sv
module pinmux_regfile
    import pinmux_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SLOT_W-1:0]   slot,
    input  acc_e                kind,
    input  logic [PINS-1:0]     wmask,
    output cfg_t                cfg_q
);
    localparam int CFG_BITS = $bits(cfg_t);

    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && kind != ACC_BASE) begin
            case (slot)
                SL_OWN: cfg_d.own   = apply_alias(kind, cfg_q.own,   wmask);
                SL_OE:  cfg_d.oe    = apply_alias(kind, cfg_q.oe,    wmask);
                SL_OV:  cfg_d.ov    = apply_alias(kind, cfg_q.ov,    wmask);
                SL_PU:  cfg_d.pu    = apply_alias(kind, cfg_q.pu,    wmask);
                SL_PD:  cfg_d.pd    = apply_alias(kind, cfg_q.pd,    wmask);
                SL_FS0: cfg_d.fs[0] = apply_alias(kind, cfg_q.fs[0], wmask);
                SL_FS1: cfg_d.fs[1] = apply_alias(kind, cfg_q.fs[1], wmask);
                SL_FS2: cfg_d.fs[2] = apply_alias(kind, cfg_q.fs[2], wmask);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            cfg_q.own <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    logic [CFG_BITS-1:0] flat_q;
    assign flat_q = cfg_q;

    AST_SET_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_SET) |=> (($past(flat_q) & ~flat_q) == '0)); // R3
    AST_CLR_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_CLR) |=> ((~$past(flat_q) & flat_q) == '0)); // R4
    AST_BASE_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_BASE) |=> $stable(flat_q)); // R6
    AST_RO_WORD_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && slot >= SL_LVL) |=> $stable(flat_q)); // R6
endmodule

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pinmux_select.sv
module pinmux_select
    import pinmux_pkg::*;
#(
    parameter int NUM_FN = 8
) (
    input  logic [PINS-1:0]             own,
    input  logic [PINS-1:0]             ov,
    input  logic [PINS-1:0]             oe,
    input  logic [FSEL_W-1:0][PINS-1:0] fs,
    input  logic [NUM_FN*PINS-1:0]      fn_out,
    input  logic [NUM_FN*PINS-1:0]      fn_oe,
    output logic [PINS-1:0]             pad_out,
    output logic [PINS-1:0]             pad_oe
);
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        logic [FSEL_W-1:0] code;
        always_comb begin
            for (int b = 0; b < FSEL_W; b++) code[b] = fs[b][p];
        end

        always_comb begin
            pad_out[p] = 1'b0;
            pad_oe[p]  = 1'b0;
            if (own[p]) begin
                pad_out[p] = ov[p];
                pad_oe[p]  = oe[p];
            end else if (int'(code) < NUM_FN) begin
                pad_out[p] = fn_out[int'(code)*PINS + p];
                pad_oe[p]  = fn_oe[int'(code)*PINS + p];
            end
        end
    end
endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
    import pinmux_pkg::*;
#(
    parameter int NUM_FN  = 8,
    parameter int PORT_ID = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [PINS-1:0]        bus_wdata,
    output logic [PINS-1:0]        bus_rdata,
    input  logic [PINS-1:0]        pad_in_i,
    output logic [PINS-1:0]        pad_out_o,
    output logic [PINS-1:0]        pad_oe_o,
    output logic [PINS-1:0]        pull_up_o,
    output logic [PINS-1:0]        pull_dn_o,
    input  logic [NUM_FN*PINS-1:0] fn_out_i,
    input  logic [NUM_FN*PINS-1:0] fn_oe_i
);
    localparam int                SLOT_LSB = 4;
    localparam int                PORT_LSB = SLOT_LSB + SLOT_W;
    localparam logic [PORT_W-1:0] MY_PORT  = PORT_W'(PORT_ID);

    logic              hit;
    logic              wr_en;
    logic [SLOT_W-1:0] slot;
    acc_e              kind;
    cfg_t              cfg_q;
    logic [PINS-1:0]   level;

    assign hit   = bus_valid && (bus_addr[PORT_LSB +: PORT_W] == MY_PORT)
                   && (bus_addr[1:0] == 2'b00);
    assign wr_en = hit && bus_write;
    assign slot  = bus_addr[SLOT_LSB +: SLOT_W];
    assign kind  = acc_e'(bus_addr[3:2]);

    pinmux_regfile u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .slot  (slot),
        .kind  (kind),
        .wmask (bus_wdata),
        .cfg_q (cfg_q)
    );

    pinmux_sync #(.WIDTH(PINS), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in_i),
        .sync_o  (level)
    );

    pinmux_select #(.NUM_FN(NUM_FN)) u_sel (
        .own     (cfg_q.own),
        .ov      (cfg_q.ov),
        .oe      (cfg_q.oe),
        .fs      (cfg_q.fs),
        .fn_out  (fn_out_i),
        .fn_oe   (fn_oe_i),
        .pad_out (pad_out_o),
        .pad_oe  (pad_oe_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit && !bus_write && kind == ACC_BASE) begin
            case (slot)
                SL_OWN: bus_rdata = cfg_q.own;
                SL_OE:  bus_rdata = cfg_q.oe;
                SL_OV:  bus_rdata = cfg_q.ov;
                SL_PU:  bus_rdata = cfg_q.pu;
                SL_PD:  bus_rdata = cfg_q.pd;
                SL_FS0: bus_rdata = cfg_q.fs[0];
                SL_FS1: bus_rdata = cfg_q.fs[1];
                SL_FS2: bus_rdata = cfg_q.fs[2];
                SL_LVL: bus_rdata = level;
                SL_ODL: bus_rdata = ~cfg_q.oe;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign pull_up_o = cfg_q.pu;
    assign pull_dn_o = cfg_q.pd;

    AST_OWNED_PIN_FOLLOWS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_oe_o ^ cfg_q.oe) | (pad_out_o ^ cfg_q.ov)) & cfg_q.own) == '0); // R9
    AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr[3:2] != 2'b00) |-> bus_rdata == '0); // R7
    AST_FOREIGN_PORT_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr[PORT_LSB +: PORT_W] != MY_PORT) |=> $stable(cfg_q)); // R1
endmodule

// File: tb/pinmux_port_tb.sv
`timescale 1ns/1ps
module pinmux_port_tb;
    localparam int NFN = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [31:0]       pad_in_i = '0;
    logic [31:0]       pad_out_o, pad_oe_o, pull_up_o, pull_dn_o;
    logic [NFN*32-1:0] fn_out_i, fn_oe_i;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pinmux_port #(.NUM_FN(NFN), .PORT_ID(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in_i(pad_in_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o),
        .pull_up_o(pull_up_o), .pull_dn_o(pull_dn_o),
        .fn_out_i(fn_out_i), .fn_oe_i(fn_oe_i)
    );

    typedef struct packed {
        logic [11:0] wa;
        logic [31:0] wd;
        logic [11:0] ra;
        logic [31:0] ex;
        logic [7:0]  rq;
    } vec_t;

    // Port 2 base 0x200; word n at 0x200 + 0x10*n; +4 set, +8 clear, +C toggle.
    localparam vec_t VEC [15] = '{
        '{12'h204, 32'h0000_0000, 12'h200, 32'hFFFF_FFFF, 8'd3},  // R3 zero mask keeps
        '{12'h208, 32'h0000_00FF, 12'h200, 32'hFFFF_FF00, 8'd4},  // R4
        '{12'h20C, 32'h0000_0F0F, 12'h200, 32'hFFFF_F00F, 8'd5},  // R5
        '{12'h214, 32'h0000_00F1, 12'h210, 32'h0000_00F1, 8'd3},  // R3
        '{12'h294, 32'h0000_FFFF, 12'h290, 32'hFFFF_FF0E, 8'd12}, // R12, R6
        '{12'h220, 32'hFFFF_FFFF, 12'h220, 32'h0000_0000, 8'd6},  // R6 base write
        '{12'h324, 32'h0000_FFFF, 12'h220, 32'h0000_0000, 8'd1},  // R1 other port
        '{12'h226, 32'h0000_FFFF, 12'h220, 32'h0000_0000, 8'd1},  // R1 misaligned
        '{12'h224, 32'h0000_0031, 12'h224, 32'h0000_0000, 8'd7},  // R7 alias read
        '{12'h234, 32'h0000_0003, 12'h230, 32'h0000_0003, 8'd13}, // R13
        '{12'h244, 32'h0000_0006, 12'h240, 32'h0000_0006, 8'd13}, // R13
        '{12'h254, 32'h0000_00F0, 12'h250, 32'h0000_00F0, 8'd2},  // R2
        '{12'h264, 32'h0000_00C0, 12'h260, 32'h0000_00C0, 8'd2},  // R2
        '{12'h274, 32'h0000_00A0, 12'h270, 32'h0000_00A0, 8'd2},  // R2
        '{12'h2A4, 32'h0000_FFFF, 12'h2A0, 32'h0000_0000, 8'd7}   // R7 unmapped
    };

    function automatic logic [31:0] pat_out(int f);
        logic [31:0] seed = 32'h9E37_79B9;
        return (seed << (3*f)) | (seed >> (32 - 3*f));
    endfunction

    function automatic logic [31:0] pat_oe(int f);
        return pat_out(f + 1) ^ 32'h0F0F_0F0F;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int codes [12] = '{0, 0, 0, 0, 1, 5, 3, 7, 0, 0, 0, 0};
        for (int f = 0; f < NFN; f++) begin
            fn_out_i[f*32 +: 32] = pat_out(f);
            fn_oe_i[f*32 +: 32]  = pat_oe(f);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        rd(12'h200, r); check("R8 own", r, 32'hFFFF_FFFF);
        rd(12'h210, r); check("R8 oe", r, 32'h0);
        rd(12'h270, r); check("R8 fsel2", r, 32'h0);
        check("R8 pad_oe", pad_oe_o, 32'h0);
        check("R8 pad_out", pad_out_o, 32'h0);
        check("R8 pulls", pull_up_o | pull_dn_o, 32'h0);

        for (int i = 0; i < 15; i++) begin
            wr(VEC[i].wa, VEC[i].wd);
            rd(VEC[i].ra, r);
            check($sformatf("R%0d vector %0d", VEC[i].rq, i), r, VEC[i].ex);
        end

        // R9 owned pin 0: ov=1, oe=1
        check("R9 pin0 out", 32'(pad_out_o[0]), 32'd1);
        check("R9 pin0 oe", 32'(pad_oe_o[0]), 32'd1);
        // R10 function-driven pins 4..11
        for (int p = 4; p < 12; p++) begin
            check($sformatf("R10 pin%0d out", p), 32'(pad_out_o[p]), 32'(pat_out(codes[p])[p]));
            check($sformatf("R10 pin%0d oe", p), 32'(pad_oe_o[p]), 32'(pat_oe(codes[p])[p]));
        end
        // R13 bus keeper on pin 1
        check("R13 keeper", pull_up_o & pull_dn_o, 32'h0000_0002);
        check("R13 pull_up", pull_up_o, 32'h3);

        // R9 handing pin 4 back to the port
        wr(12'h204, 32'h0000_0010);
        check("R9 pin4 out", 32'(pad_out_o[4]), 32'd1);
        check("R9 pin4 oe", 32'(pad_oe_o[4]), 32'd1);

        // R11 two-edge synchroniser
        @(negedge clk);
        pad_in_i = 32'hA5A5_0001;
        @(negedge clk);
        rd(12'h280, r); check("R11 after one edge", r, 32'h0);
        @(negedge clk);
        rd(12'h280, r); check("R11 after two edges", r, 32'hA5A5_0001);

        // R12 open-drain emulation: toggle oe on pin 3
        wr(12'h21C, 32'h0000_0008);
        rd(12'h290, r); check("R12 od level", r, ~32'h0000_00F9);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule